// File: doc/BRIEF.md
# Four-Tap Multiply-Accumulate Filter with Banked Coefficients

This block is a pipelined filter core. On every clock it takes four signed data samples and multiplies each one by a signed coefficient. Each tap has its own coefficient bank, and every bank holds 32 coefficient sets. A set address picks the same set in all four banks. The four products are added together. The sum then either starts a new total in a wide accumulator or is added to the total already there. The accumulated value is reduced to a 16-bit result. In integer form the low bits are kept with saturation. In fractional form the high bits are kept, with round-half-up and saturation.

Coefficients are written through a slow three-wire serial port: bit clock, bit data and a frame enable. A per-bank mask and a word address steer each write. The serial clock is not used as a clock. All three serial wires are synchronised into the core clock, and their edges are detected there.

Every data and control input travels down the pipeline with its sample. A result therefore appears five core clocks after its inputs are captured. A hold input freezes the result register, while the accumulator keeps running. An output-enable input forces the result to zero and lowers the valid flag without waiting for a clock.

Top module: `quad_mac_filter`

## Requirements
- R1: While reset is asserted, the result is 0, the valid flag is low, and every stored coefficient reads as 0.
- R2: With `out_en` high, `result_valid` stays low for the first four core clock edges after reset is released and goes high on the fifth edge, then stays high.
- R3: `din` carries tap k in bits [10k+9:10k] as two's complement. The accumulated value is the sum over the four taps of tap data times the tap's coefficient. The result for a sample appears after the fifth rising edge, counting from the edge that captures the sample.
- R4: `set_sel` selects one of 32 coefficient words in every bank. A word that was never written contributes zero.
- R5: `acc_add` = 0 loads the accumulator with the new sum. `acc_add` = 1 adds the new sum to the previous accumulator value. The control acts on the sample captured with it.
- R6: With `frac_sel` = 0, the result is the 25-bit accumulator value clamped to the range -32768 to 32767.
- R7: With `frac_sel` = 1, the result is (accumulator + 256) shifted arithmetically right by 9, clamped to the range -32768 to 32767.
- R8: `hold` = 1, captured with a sample, keeps the result at its previous value in the cycle where that sample's result would appear. The accumulator still updates.
- R9: While `out_en` is low, `result` is 0 and `result_valid` is low at once, without waiting for a clock. Raising `out_en` again shows the held value.
- R10: The serial port works as follows. While `ser_en` is high, each rising edge of `ser_clk` shifts in `ser_dat`, MSB first, and only the last 11 bits are kept. When `ser_en` falls, the word is written at `ser_addr` in each bank whose `ser_mask` bit is set (bit k for tap k). Banks whose mask bit is clear keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 40 | Four packed signed 10-bit samples |
| set_sel | input | 5 | Coefficient set address |
| acc_add | input | 1 | 1: add to accumulator, 0: load accumulator |
| frac_sel | input | 1 | 1: fractional rounding, 0: integer clamp |
| hold | input | 1 | Freeze the result register for this sample |
| out_en | input | 1 | Result enable, also gates the valid flag |
| ser_clk | input | 1 | Serial bit clock (sampled) |
| ser_dat | input | 1 | Serial coefficient data |
| ser_en | input | 1 | Serial frame enable; falling edge commits |
| ser_addr | input | 5 | Coefficient word address for serial write |
| ser_mask | input | 4 | Bank select mask for serial write |
| result | output | 16 | Rounded and saturated filter output |
| result_valid | output | 1 | Pipeline filled and output enabled |

## Verification
The bench drives the largest products of both signs in integer mode. A design that wraps instead of clamping would show a small or sign-flipped value there. In fractional mode it places the accumulator just above and just below the half-LSB point on both sides of zero. A design that truncates, or rounds toward zero, gives results that differ by one. It asserts hold partway through an accumulation run. A design that also stalled the accumulator would report one sample short on the following output. It loads words with a partial bank mask and with extra leading bits. A design that writes every bank, or keeps the first 11 bits, would corrupt the sums that follow. It also counts the exact edge where the valid flag rises after reset.

// File: rtl/qmf_pkg.sv
package qmf_pkg;

    localparam int PIPE_LAT = 5;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_SHIFT,
        LD_WRITE
    } ld_state_e;

    typedef enum logic {
        PF_FILL,
        PF_RUN
    } pf_state_e;

endpackage

// File: rtl/qmf_coef_loader.sv
module qmf_coef_loader
    import qmf_pkg::*;
#(
    parameter int TAPS   = 4,
    parameter int COEF_W = 11,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en,
    input  logic [ADDR_W-1:0] ser_addr,
    input  logic [TAPS-1:0]   ser_mask,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [TAPS-1:0]   wr_mask,
    output logic [COEF_W-1:0] wr_word
);

    localparam int SYNC_D = 3;

    logic [SYNC_D-1:0] sclk_sync;
    logic [SYNC_D-1:0] en_sync;
    logic [1:0]        dat_sync;
    logic              sclk_rise;
    logic              en_now;
    logic              dat_bit;
    ld_state_e         state;
    ld_state_e         nxt;

    // two-flop synchronisers plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sync <= '0;
            en_sync   <= '0;
            dat_sync  <= '0;
        end else begin
            sclk_sync <= {sclk_sync[SYNC_D-2:0], ser_clk};
            en_sync   <= {en_sync[SYNC_D-2:0], ser_en};
            dat_sync  <= {dat_sync[0], ser_dat};
        end
    end

    assign sclk_rise = sclk_sync[1] & ~sclk_sync[2];
    assign en_now    = en_sync[1];
    assign dat_bit   = dat_sync[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            LD_IDLE:  if (en_now)  nxt = LD_SHIFT;
            LD_SHIFT: if (!en_now) nxt = LD_WRITE;
            LD_WRITE: nxt = LD_IDLE;
            default:  nxt = LD_IDLE;
        endcase
    end

    // shift register and write target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_word <= '0;
            wr_addr <= '0;
            wr_mask <= '0;
        end else begin
            unique case (state)
                LD_IDLE: begin
                    if (en_now) wr_word <= '0;
                end
                LD_SHIFT: begin
                    if (!en_now) begin
                        wr_addr <= ser_addr;
                        wr_mask <= ser_mask;
                    end else if (sclk_rise) begin
                        wr_word <= {wr_word[COEF_W-2:0], dat_bit};
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en = (state == LD_WRITE);
    end

endmodule

// File: rtl/qmf_coef_bank.sv
module qmf_coef_bank #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 11,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/qmf_mac_pipe.sv
module qmf_mac_pipe
    import qmf_pkg::*;
#(
    parameter int TAPS       = 4,
    parameter int DATA_W     = 10,
    parameter int COEF_W     = 11,
    parameter int ADDR_W     = 5,
    parameter int ACC_W      = 25,
    parameter int OUT_W      = 16,
    parameter int FRAC_SHIFT = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TAPS*DATA_W-1:0]   din,
    input  logic [ADDR_W-1:0]        set_sel,
    input  logic                     acc_add,
    input  logic                     frac_sel,
    input  logic                     hold,
    input  logic [TAPS*COEF_W-1:0]   coef_flat,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic [OUT_W-1:0]         out_q,
    output logic                     hold_al,
    output logic                     run
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int CNT_W  = $clog2(PIPE_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PIPE_LAT - 1);
    localparam logic signed [ACC_W:0] HALF   = (ACC_W+1)'(1) << (FRAC_SHIFT - 1);
    localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W:0] SAT_LO = -SAT_HI - (ACC_W+1)'(1);

    logic signed [DATA_W-1:0] d_s1   [TAPS];
    logic signed [COEF_W-1:0] coef   [TAPS];
    logic signed [PROD_W-1:0] prod_s2[TAPS];
    logic signed [ACC_W-1:0]  sum_c;
    logic signed [ACC_W-1:0]  sum_s3;
    logic signed [ACC_W-1:0]  acc_s4;
    logic [ADDR_W-1:0]        addr_s1;
    logic mode_s1, mode_s2, mode_s3;
    logic frac_s1, frac_s2, frac_s3, frac_s4;
    logic hold_s1, hold_s2, hold_s3, hold_s4;
    pf_state_e                state;
    pf_state_e                nxt;
    logic [CNT_W-1:0]         fill_cnt;

    function automatic logic [OUT_W-1:0] round_sat(input logic signed [ACC_W-1:0] a,
                                                   input logic frac);
        logic signed [ACC_W:0] ext;
        logic signed [ACC_W:0] t;
        ext = {a[ACC_W-1], a};
        if (frac) t = (ext + HALF) >>> FRAC_SHIFT;
        else      t = ext;
        if (t > SAT_HI)      return SAT_HI[OUT_W-1:0];
        else if (t < SAT_LO) return SAT_LO[OUT_W-1:0];
        else                 return t[OUT_W-1:0];
    endfunction

    for (genvar k = 0; k < TAPS; k++) begin : g_coef
        assign coef[k] = coef_flat[k*COEF_W +: COEF_W];
    end

    always_comb begin
        sum_c = '0;
        for (int k = 0; k < TAPS; k++) begin
            sum_c = sum_c + {{(ACC_W-PROD_W){prod_s2[k][PROD_W-1]}}, prod_s2[k]};
        end
    end

    // five register stages: capture, multiply, sum, accumulate, output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) begin
                d_s1[k]    <= '0;
                prod_s2[k] <= '0;
            end
            addr_s1 <= '0;
            {mode_s1, mode_s2, mode_s3} <= '0;
            {frac_s1, frac_s2, frac_s3, frac_s4} <= '0;
            {hold_s1, hold_s2, hold_s3, hold_s4} <= '0;
            sum_s3 <= '0;
            acc_s4 <= '0;
            out_q  <= '0;
        end else begin
            for (int k = 0; k < TAPS; k++) begin
                d_s1[k]    <= din[k*DATA_W +: DATA_W];
                prod_s2[k] <= d_s1[k] * coef[k];
            end
            addr_s1 <= set_sel;
            mode_s1 <= acc_add;
            frac_s1 <= frac_sel;
            hold_s1 <= hold;
            mode_s2 <= mode_s1;
            frac_s2 <= frac_s1;
            hold_s2 <= hold_s1;
            sum_s3  <= sum_c;
            mode_s3 <= mode_s2;
            frac_s3 <= frac_s2;
            hold_s3 <= hold_s2;
            acc_s4  <= mode_s3 ? acc_s4 + sum_s3 : sum_s3;
            frac_s4 <= frac_s3;
            hold_s4 <= hold_s3;
            if (!hold_s4) out_q <= round_sat(acc_s4, frac_s4);
        end
    end

    assign rd_addr = addr_s1;
    assign hold_al = hold_s4;

    // pipeline fill tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PF_FILL;
            fill_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == PF_FILL) fill_cnt <= fill_cnt + CNT_W'(1);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PF_FILL: if (fill_cnt == CNT_LAST) nxt = PF_RUN;
            PF_RUN:  nxt = PF_RUN;
            default: nxt = PF_FILL;
        endcase
    end

    always_comb begin
        run = (state == PF_RUN);
    end

endmodule

// File: rtl/quad_mac_filter.sv
module quad_mac_filter
    import qmf_pkg::*;
#(
    parameter int TAPS       = 4,
    parameter int DATA_W     = 10,
    parameter int COEF_W     = 11,
    parameter int SETS       = 32,
    parameter int ACC_W      = 25,
    parameter int OUT_W      = 16,
    parameter int FRAC_SHIFT = 9,
    localparam int ADDR_W    = $clog2(SETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TAPS*DATA_W-1:0] din,
    input  logic [ADDR_W-1:0]      set_sel,
    input  logic                   acc_add,
    input  logic                   frac_sel,
    input  logic                   hold,
    input  logic                   out_en,
    input  logic                   ser_clk,
    input  logic                   ser_dat,
    input  logic                   ser_en,
    input  logic [ADDR_W-1:0]      ser_addr,
    input  logic [TAPS-1:0]        ser_mask,
    output logic [OUT_W-1:0]       result,
    output logic                   result_valid
);

    logic                   wr_en;
    logic [ADDR_W-1:0]      wr_addr;
    logic [TAPS-1:0]        wr_mask;
    logic [COEF_W-1:0]      wr_word;
    logic [ADDR_W-1:0]      rd_addr;
    logic [TAPS*COEF_W-1:0] coef_flat;
    logic [OUT_W-1:0]       out_q;
    logic                   hold_al;
    logic                   pipe_run;

    qmf_coef_loader #(
        .TAPS   (TAPS),
        .COEF_W (COEF_W),
        .ADDR_W (ADDR_W)
    ) i_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .ser_en   (ser_en),
        .ser_addr (ser_addr),
        .ser_mask (ser_mask),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_mask  (wr_mask),
        .wr_word  (wr_word)
    );

    for (genvar k = 0; k < TAPS; k++) begin : g_bank
        qmf_coef_bank #(
            .DEPTH  (SETS),
            .WIDTH  (COEF_W),
            .ADDR_W (ADDR_W)
        ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en & wr_mask[k]),
            .wr_addr (wr_addr),
            .wr_data (wr_word),
            .rd_addr (rd_addr),
            .rd_data (coef_flat[k*COEF_W +: COEF_W])
        );
    end

    qmf_mac_pipe #(
        .TAPS       (TAPS),
        .DATA_W     (DATA_W),
        .COEF_W     (COEF_W),
        .ADDR_W     (ADDR_W),
        .ACC_W      (ACC_W),
        .OUT_W      (OUT_W),
        .FRAC_SHIFT (FRAC_SHIFT)
    ) i_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .set_sel   (set_sel),
        .acc_add   (acc_add),
        .frac_sel  (frac_sel),
        .hold      (hold),
        .coef_flat (coef_flat),
        .rd_addr   (rd_addr),
        .out_q     (out_q),
        .hold_al   (hold_al),
        .run       (pipe_run)
    );

    assign result       = out_en ? out_q : '0;
    assign result_valid = out_en & pipe_run;

endmodule

// File: rtl/qmf_checks.sv
module qmf_checks #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_en,
    input logic [OUT_W-1:0] result,
    input logic             result_valid,
    input logic [OUT_W-1:0] out_q,
    input logic             hold_al,
    input logic             wr_en,
    input logic             run
);

    a_r9_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (result == '0));

    a_r9_valid_gated: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> out_en);

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        hold_al |=> $stable(out_q));

    a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

endmodule

bind quad_mac_filter qmf_checks #(.OUT_W(OUT_W)) i_qmf_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_en       (out_en),
    .result       (result),
    .result_valid (result_valid),
    .out_q        (out_q),
    .hold_al      (hold_al),
    .wr_en        (wr_en),
    .run          (pipe_run)
);

// File: tb/test_quad_mac_filter.sv
`timescale 1ns/1ps
module test_quad_mac_filter;

    localparam int NV = 16;
    // fields: {set[5], acc_add, frac_sel, hold, d3, d2, d1, d0}
    localparam logic [47:0] VT [NV] = '{
        {5'd1,  1'b0, 1'b0, 1'b0, 10'sd4,    10'sd3,    10'sd2,    10'sd1},
        {5'd1,  1'b1, 1'b0, 1'b0, 10'sd5,    10'sd5,    10'sd5,    10'sd5},
        {5'd2,  1'b0, 1'b0, 1'b0, -10'sd512, -10'sd512, 10'sd511,  10'sd511},
        {5'd2,  1'b0, 1'b0, 1'b0, 10'sd511,  10'sd511,  -10'sd512, -10'sd512},
        {5'd31, 1'b0, 1'b0, 1'b0, 10'sd40,   10'sd30,   10'sd20,   10'sd10},
        {5'd1,  1'b0, 1'b1, 1'b0, 10'sd0,    10'sd0,    10'sd0,    10'sd256},
        {5'd1,  1'b0, 1'b1, 1'b0, 10'sd0,    10'sd0,    10'sd0,    10'sd255},
        {5'd1,  1'b0, 1'b1, 1'b0, 10'sd0,    10'sd0,    10'sd0,    -10'sd257},
        {5'd1,  1'b0, 1'b1, 1'b0, 10'sd0,    10'sd0,    10'sd0,    -10'sd256},
        {5'd2,  1'b0, 1'b1, 1'b0, -10'sd512, -10'sd512, 10'sd511,  10'sd511},
        {5'd1,  1'b0, 1'b0, 1'b0, 10'sd0,    10'sd0,    10'sd0,    10'sd7},
        {5'd1,  1'b1, 1'b0, 1'b1, 10'sd0,    10'sd0,    10'sd0,    10'sd1},
        {5'd1,  1'b1, 1'b0, 1'b0, 10'sd0,    10'sd0,    10'sd0,    10'sd1},
        {5'd0,  1'b0, 1'b0, 1'b0, 10'sd100,  10'sd100,  10'sd100,  10'sd100},
        {5'd5,  1'b0, 1'b0, 1'b0, 10'sd0,    10'sd3,    10'sd0,    10'sd5},
        {5'd2,  1'b1, 1'b0, 1'b0, 10'sd0,    10'sd0,    10'sd0,    10'sd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] din = '0;
    logic [4:0]  set_sel = '0;
    logic        acc_add = 1'b0;
    logic        frac_sel = 1'b0;
    logic        hold = 1'b0;
    logic        out_en = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_en = 1'b0;
    logic [4:0]  ser_addr = '0;
    logic [3:0]  ser_mask = '0;
    logic [15:0] result;
    logic        result_valid;

    int tests = 0;
    int fails = 0;
    int coef_m [4][32];
    int exp_out [NV];

    always #5 clk = ~clk;

    quad_mac_filter i_quad_mac_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .din          (din),
        .set_sel      (set_sel),
        .acc_add      (acc_add),
        .frac_sel     (frac_sel),
        .hold         (hold),
        .out_en       (out_en),
        .ser_clk      (ser_clk),
        .ser_dat      (ser_dat),
        .ser_en       (ser_en),
        .ser_addr     (ser_addr),
        .ser_mask     (ser_mask),
        .result       (result),
        .result_valid (result_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input longint a, input bit frac);
        longint t;
        t = frac ? ((a + 256) >>> 9) : a;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return int'(t);
    endfunction

    function automatic string vreq(input int i);
        case (i)
            0: return "R3";
            1, 12: return "R5";
            2, 3: return "R6";
            5, 6, 7, 8, 9: return "R7";
            10, 11: return "R8";
            13: return "R4";
            4, 14: return "R10";
            default: return "R5";
        endcase
    endfunction

    task automatic sbit(input logic v);
        ser_dat = v;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic load_word(input logic [3:0] mask, input int addr, input int value,
                             input int junk);
        logic [10:0] w;
        w = value[10:0];
        @(negedge clk);
        ser_addr = addr[4:0];
        ser_mask = mask;
        ser_en   = 1'b1;
        repeat (4) @(negedge clk);
        for (int b = 0; b < junk; b++) sbit(1'b1);
        for (int b = 10; b >= 0; b--) sbit(w[b]);
        ser_en = 1'b0;
        repeat (8) @(negedge clk);
        for (int k = 0; k < 4; k++) if (mask[k]) coef_m[k][addr] = value;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        longint acc_m;
        int     prev;
        for (int k = 0; k < 4; k++) for (int a = 0; a < 32; a++) coef_m[k][a] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", int'($signed(result)), 0);
        chk("R1", int'(result_valid), 0);
        rst_n = 1'b1;
        // R2: valid rises on the fifth edge after release
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            chk("R2", int'(result_valid), (c == 5) ? 1 : 0);
        end

        // coefficient loads (R10)
        load_word(4'b1111, 1, 1, 0);
        load_word(4'b0001, 2, 1023, 0);
        load_word(4'b0010, 2, 1023, 0);
        load_word(4'b0100, 2, -1024, 0);
        load_word(4'b1000, 2, -1024, 0);
        load_word(4'b0001, 31, -1, 2);
        load_word(4'b0010, 31, 2, 0);
        load_word(4'b0100, 31, -3, 0);
        load_word(4'b1000, 31, 4, 1);
        load_word(4'b0100, 5, 300, 0);
        repeat (6) @(negedge clk);
        chk("R1", int'($signed(result)), 0);

        acc_m = 0;
        prev  = 0;
        for (int i = 0; i < NV + 5; i++) begin
            @(negedge clk);
            if (i >= 5) chk(vreq(i - 5), int'($signed(result)), exp_out[i - 5]);
            if (i < NV) begin
                logic [47:0] v;
                longint      sum;
                int          a;
                v = VT[i];
                a = int'(v[47:43]);
                sum = 0;
                for (int k = 0; k < 4; k++) begin
                    logic signed [9:0] dk;
                    dk = v[k*10 +: 10];
                    sum += longint'(dk) * coef_m[k][a];
                end
                acc_m = v[42] ? acc_m + sum : sum;
                exp_out[i] = v[40] ? prev : rnd(acc_m, v[41]);
                prev = exp_out[i];
                din      = v[39:0];
                set_sel  = v[47:43];
                acc_add  = v[42];
                frac_sel = v[41];
                hold     = v[40];
            end else begin
                din = '0; set_sel = '0; acc_add = 1'b0; frac_sel = 1'b0; hold = 1'b1;
            end
        end

        // R9: output enable gating
        @(negedge clk);
        chk("R8", int'($signed(result)), exp_out[NV - 1]);
        out_en = 1'b0;
        #1;
        chk("R9", int'($signed(result)), 0);
        chk("R9", int'(result_valid), 0);
        out_en = 1'b1;
        #1;
        chk("R9", int'($signed(result)), exp_out[NV - 1]);
        chk("R9", int'(result_valid), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule